// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the front end of a transmit DMA path. Software places frame descriptors in an internal ring of register-resident slots, then moves a 16-bit producer index forward to post them. The engine has its own fetch position and a consumer index that software can see. Each time the fetch position differs from the producer index, the engine does the following: it reads the descriptor in the current slot, splits the buffer into memory read bursts, and forwards the returned bytes on a byte stream. That stream carries start-of-frame, end-of-frame and append-CRC markers.

One frame can span several buffers. A buffer that does not carry the end flag moves the fetch position forward and leaves the consumer index alone. When the last byte of the end-of-frame buffer is accepted downstream, the consumer index jumps to just past that descriptor, so all descriptors of the frame are released together. The engine needs two enable bits before it starts a new frame: a global one and the one belonging to its ring. It checks them only between frames. A frame already in progress always runs to completion.

A MAC sits downstream and adds the CRC, so this block does not compute one. The memory read port and the byte stream both use plain valid/ready handshakes.

Top module: `txring_fetcher`

## Requirements
- R1: While reset is held and right after it, `cons_idx` is 0, `rd_req_valid` is low and `tx_valid` is low.
- R2: Work is pending whenever the fetch position differs from the producer index in all 16 bits. Once every posted descriptor has been handled, the engine issues no further requests or bytes.
- R3: A descriptor's buffer length is bits 27:16 of its status word (`desc_sel`=0). Its byte address is {high word (`desc_sel`=2), low word (`desc_sel`=1)}. The bytes come out on `tx_data` in address order, exactly length bytes per buffer.
- R4: Every read request asks for between 1 and 8 beats of one byte each. That count is the smaller of 8 and the bytes still owed for the buffer. Successive requests of a buffer start at consecutive addresses. A request is held stable until `rd_req_ready` accepts it.
- R5: Status bit 13 (start) marks the first byte of its buffer with `tx_sof`. Status bit 14 (end) marks the last byte with `tx_eof`. Status bit 6 (append CRC) is copied to `tx_crc` on every byte of that buffer.
- R6: The consumer index changes only when a buffer that carries the end flag finishes. It then becomes that descriptor's index plus one. A buffer without the end flag leaves it unchanged.
- R7: A new frame starts only while both `run_ctrl[0]` (global) and `run_ctrl[17]` (ring 16 enable) are set. With either one clear, no request is made at a frame boundary and both indices hold. Clearing an enable in the middle of a multi-buffer frame does not stop that frame.
- R8: The descriptor slot is the low 8 bits of the fetch position, so slot 255 is followed by slot 0.
- R9: A descriptor with length 0 produces no request and no byte. It still moves the fetch position forward, and it advances the consumer index when it carries the end flag.
- R10: Under back-pressure on both the stream and the request port, and with gaps in the returned data, the byte sequence and its markers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_we | input | 1 | Descriptor word write strobe |
| desc_slot | input | 8 | Slot to write |
| desc_sel | input | 2 | Word select: 0 status, 1 low address, 2 high address |
| desc_wdata | input | 32 | Descriptor word value |
| prod_we | input | 1 | Producer index write strobe |
| prod_wdata | input | 16 | New producer index |
| run_ctrl | input | 18 | Bit 0 global enable, bit 17 ring 16 enable |
| cons_idx | output | 16 | Consumer index |
| rd_req_valid | output | 1 | Read burst request valid |
| rd_req_ready | input | 1 | Read burst request accepted |
| rd_req_addr | output | 64 | Burst start byte address |
| rd_req_beats | output | 4 | Burst length in bytes (1 to 8) |
| rd_dat_valid | input | 1 | Returned byte valid |
| rd_dat_ready | output | 1 | Returned byte accepted |
| rd_dat | input | 8 | Returned byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a start buffer |
| tx_eof | output | 1 | Last byte of an end buffer |
| tx_crc | output | 1 | Append-CRC request for this buffer |

## Verification
The hardest point to reach from the ports is the wrap of the descriptor slot from 255 to 0 with a real frame on each side of it, because that normally needs hundreds of frames. The stimulus instead posts one long run of zero-length end descriptors. Each retires in two cycles without touching memory, which carries the fetch position to slot 255 quickly and also exercises R9 in bulk. A second hard case is an enable dropped in the middle of a frame. To set it up, the bench posts only the first buffer of a two-buffer frame, waits until that buffer has streamed, clears the enables, and then posts the end buffer.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  // Field positions inside the status word; the stream markers decode them.
  localparam int unsigned LEN_LSB  = 16;
  localparam int unsigned LEN_BITS = 12;
  localparam int unsigned BIT_EOP  = 14;
  localparam int unsigned BIT_SOP  = 13;
  localparam int unsigned BIT_CRC  = 6;

  // Word lanes of one descriptor slot.
  localparam int unsigned LANE_STAT = 0;
  localparam int unsigned LANE_LO   = 1;
  localparam int unsigned LANE_HI   = 2;
  localparam int unsigned LANES     = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } fetch_st_e;

  typedef struct packed {
    logic [63:0]         addr;
    logic [LEN_BITS-1:0] len;
    logic                sop;
    logic                eop;
    logic                crc;
  } tx_desc_t;

  function automatic tx_desc_t unpack_desc(input logic [31:0] stat,
                                           input logic [31:0] lo,
                                           input logic [31:0] hi);
    tx_desc_t d;
    d.addr = {hi, lo};
    d.len  = stat[LEN_LSB +: LEN_BITS];
    d.sop  = stat[BIT_SOP];
    d.eop  = stat[BIT_EOP];
    d.crc  = stat[BIT_CRC];
    return d;
  endfunction

  // Size of the next burst: whatever is left, capped at the burst limit.
  function automatic logic [LEN_BITS-1:0] next_burst(input logic [LEN_BITS-1:0] left,
                                                     input logic [LEN_BITS-1:0] cap);
    return (left < cap) ? left : cap;
  endfunction

endpackage

// File: rtl/ftx_desc_store.sv
module ftx_desc_store #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [31:0]       rd_stat,
  output logic [31:0]       rd_lo,
  output logic [31:0]       rd_hi
);
  import ftx_pkg::*;

  logic [31:0] lane_q [LANES];

  for (genvar w = 0; w < LANES; w++) begin : g_lane
    logic [31:0] words [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == 2'(w))) words[wr_slot] <= wr_data;
    end
    assign lane_q[w] = words[rd_slot];
  end

  assign rd_stat = lane_q[LANE_STAT];
  assign rd_lo   = lane_q[LANE_LO];
  assign rd_hi   = lane_q[LANE_HI];

endmodule

// File: rtl/ftx_index_unit.sv
module ftx_index_unit #(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prod_we,
  input  logic [IDX_W-1:0] prod_wd,
  input  logic             step,
  input  logic             commit,
  output logic [IDX_W-1:0] prod_q,
  output logic [IDX_W-1:0] fetch_q,
  output logic [IDX_W-1:0] cons_q,
  output logic             pending,
  output logic             at_boundary
);

  logic [IDX_W-1:0] fetch_nx;
  assign fetch_nx = fetch_q + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      fetch_q <= '0;
      cons_q  <= '0;
    end else begin
      if (prod_we) prod_q  <= prod_wd;
      if (step)    fetch_q <= fetch_nx;
      if (commit)  cons_q  <= fetch_nx;
    end
  end

  // Full-width compare: index wrap at 2**IDX_W is handled by equality.
  assign pending     = (prod_q != fetch_q);
  assign at_boundary = (fetch_q == cons_q);

endmodule

// File: rtl/ftx_burst_engine.sv
module ftx_burst_engine #(
  parameter int unsigned MAX_BURST = 8,
  parameter int unsigned BEAT_W    = $clog2(MAX_BURST + 1),
  parameter int unsigned DATA_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_ok,
  input  logic                pending,
  input  logic                at_boundary,
  input  ftx_pkg::tx_desc_t   desc_in,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [63:0]         req_addr,
  output logic [BEAT_W-1:0]   req_beats,
  input  logic                dat_valid,
  output logic                dat_ready,
  input  logic [DATA_W-1:0]   dat_in,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [DATA_W-1:0]   tx_data,
  output logic                tx_sof,
  output logic                tx_eof,
  output logic                tx_crc,
  output logic                step,
  output logic                commit,
  output logic                idle
);
  import ftx_pkg::*;

  fetch_st_e           st;
  logic [LEN_BITS-1:0] rem;
  logic [BEAT_W-1:0]   burst_left;
  logic [63:0]         next_addr;
  logic                first_q;
  logic                cur_sop, cur_eop, cur_crc;

  logic                go;
  logic                beat;
  logic [BEAT_W-1:0]   beats_now;
  logic                last_byte;

  // A new frame needs the enables; a partly sent frame does not.
  assign go        = pending && (run_ok || !at_boundary);
  assign beat      = (st == ST_DATA) && dat_valid && tx_ready;
  assign beats_now = BEAT_W'(next_burst(rem, LEN_BITS'(MAX_BURST)));
  assign last_byte = (rem == LEN_BITS'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      rem        <= '0;
      burst_left <= '0;
      next_addr  <= '0;
      first_q    <= 1'b0;
      cur_sop    <= 1'b0;
      cur_eop    <= 1'b0;
      cur_crc    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            rem       <= desc_in.len;
            next_addr <= desc_in.addr;
            cur_sop   <= desc_in.sop;
            cur_eop   <= desc_in.eop;
            cur_crc   <= desc_in.crc;
            first_q   <= 1'b1;
            st        <= (desc_in.len == '0) ? ST_FIN : ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ready) begin
            burst_left <= beats_now;
            next_addr  <= next_addr + 64'(beats_now);
            st         <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (beat) begin
            rem        <= rem - LEN_BITS'(1);
            burst_left <= burst_left - BEAT_W'(1);
            first_q    <= 1'b0;
            if (last_byte)                        st <= ST_FIN;
            else if (burst_left == BEAT_W'(1))    st <= ST_REQ;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Request side: address register already points at the next burst.
  assign req_valid = (st == ST_REQ);
  assign req_addr  = next_addr;
  assign req_beats = beats_now;

  // Data side: bytes pass straight through while a burst is open.
  assign dat_ready = (st == ST_DATA) && tx_ready;
  assign tx_valid  = (st == ST_DATA) && dat_valid;
  assign tx_data   = dat_in;
  assign tx_sof    = cur_sop && first_q;
  assign tx_eof    = cur_eop && last_byte;
  assign tx_crc    = cur_crc;

  assign step   = (st == ST_FIN);
  assign commit = (st == ST_FIN) && cur_eop;
  assign idle   = (st == ST_IDLE);

endmodule

// File: rtl/txring_fetcher.sv
module txring_fetcher #(
  parameter int unsigned RING_DEPTH = 256,
  parameter int unsigned IDX_W      = 16,
  parameter int unsigned MAX_BURST  = 8,
  parameter int unsigned RING_ID    = 16,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned SLOT_W    = $clog2(RING_DEPTH),
  localparam int unsigned BEAT_W    = $clog2(MAX_BURST + 1),
  localparam int unsigned CTRL_W    = RING_ID + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_we,
  input  logic [SLOT_W-1:0] desc_slot,
  input  logic [1:0]        desc_sel,
  input  logic [31:0]       desc_wdata,
  input  logic              prod_we,
  input  logic [IDX_W-1:0]  prod_wdata,
  input  logic [CTRL_W-1:0] run_ctrl,
  output logic [IDX_W-1:0]  cons_idx,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [63:0]       rd_req_addr,
  output logic [BEAT_W-1:0] rd_req_beats,
  input  logic              rd_dat_valid,
  output logic              rd_dat_ready,
  input  logic [DATA_W-1:0] rd_dat,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_crc
);
  import ftx_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic [IDX_W-1:0] prod_q;
  logic [IDX_W-1:0] fetch_q;
  logic             pending;
  logic             at_boundary;
  logic             step_evt;
  logic             commit_evt;
  logic             eng_idle;
  logic             run_ok;
  logic [31:0]      slot_stat, slot_lo, slot_hi;
  tx_desc_t         slot_desc;

  assign run_ok = run_ctrl[0] && run_ctrl[RING_ID + 1];

  logic unused_ctrl;
  assign unused_ctrl = ^run_ctrl[RING_ID:1];

  ftx_desc_store #(.DEPTH(RING_DEPTH), .SLOT_W(SLOT_W)) u_store (
    .clk     (clk),
    .wr_en   (desc_we),
    .wr_slot (desc_slot),
    .wr_sel  (desc_sel),
    .wr_data (desc_wdata),
    .rd_slot (fetch_q[SLOT_W-1:0]),
    .rd_stat (slot_stat),
    .rd_lo   (slot_lo),
    .rd_hi   (slot_hi)
  );

  assign slot_desc = unpack_desc(slot_stat, slot_lo, slot_hi);

  ftx_index_unit #(.IDX_W(IDX_W)) u_idx (
    .clk         (clk),
    .rst_n       (rst_n),
    .prod_we     (prod_we),
    .prod_wd     (prod_wdata),
    .step        (step_evt),
    .commit      (commit_evt),
    .prod_q      (prod_q),
    .fetch_q     (fetch_q),
    .cons_q      (cons_idx),
    .pending     (pending),
    .at_boundary (at_boundary)
  );

  ftx_burst_engine #(.MAX_BURST(MAX_BURST), .BEAT_W(BEAT_W), .DATA_W(DATA_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_ok      (run_ok),
    .pending     (pending),
    .at_boundary (at_boundary),
    .desc_in     (slot_desc),
    .req_valid   (rd_req_valid),
    .req_ready   (rd_req_ready),
    .req_addr    (rd_req_addr),
    .req_beats   (rd_req_beats),
    .dat_valid   (rd_dat_valid),
    .dat_ready   (rd_dat_ready),
    .dat_in      (rd_dat),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_sof      (tx_sof),
    .tx_eof      (tx_eof),
    .tx_crc      (tx_crc),
    .step        (step_evt),
    .commit      (commit_evt),
    .idle        (eng_idle)
  );

endmodule

// File: rtl/txring_fetcher_chk.sv
module txring_fetcher_chk #(
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned MAX_BURST = 8,
  parameter int unsigned BEAT_W    = $clog2(MAX_BURST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [63:0]       rd_req_addr,
  input logic [BEAT_W-1:0] rd_req_beats,
  input logic [IDX_W-1:0]  prod_q,
  input logic [IDX_W-1:0]  fetch_q,
  input logic [IDX_W-1:0]  cons_idx,
  input logic              run_ok,
  input logic              eng_idle,
  input logic              commit_evt
);

  logic [IDX_W-1:0] lag_fetch, lag_prod;
  assign lag_fetch = fetch_q - cons_idx;
  assign lag_prod  = prod_q - cons_idx;

  // R4
  beats_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_beats != '0) && (rd_req_beats <= BEAT_W'(MAX_BURST)));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_beats)));

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lag_fetch <= lag_prod);

  // R6
  cons_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_idx != $past(cons_idx)) |-> $past(commit_evt));

  // R7
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !run_ok && (fetch_q == cons_idx)) |=> !rd_req_valid);

endmodule

bind txring_fetcher txring_fetcher_chk #(
  .IDX_W(IDX_W), .MAX_BURST(MAX_BURST), .BEAT_W(BEAT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_req_beats (rd_req_beats),
  .prod_q       (prod_q),
  .fetch_q      (fetch_q),
  .cons_idx     (cons_idx),
  .run_ok       (run_ok),
  .eng_idle     (eng_idle),
  .commit_evt   (commit_evt)
);

// File: tb/sim_txring_fetcher.sv
module sim_txring_fetcher;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [31:0] F_SOP = 32'h0000_2000;
  localparam logic [31:0] F_EOP = 32'h0000_4000;
  localparam logic [31:0] F_CRC = 32'h0000_0040;
  localparam logic [17:0] RUN_ALL = 18'h2_0001;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        desc_we;
  logic [7:0]  desc_slot;
  logic [1:0]  desc_sel;
  logic [31:0] desc_wdata;
  logic        prod_we;
  logic [15:0] prod_wdata;
  logic [17:0] run_ctrl;
  logic [15:0] cons_idx;
  logic        rd_req_valid, rd_req_ready;
  logic [63:0] rd_req_addr;
  logic [3:0]  rd_req_beats;
  logic        rd_dat_valid, rd_dat_ready;
  logic [7:0]  rd_dat;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        tx_sof, tx_eof, tx_crc;

  txring_fetcher u0 (
    .clk(clk), .rst_n(rst_n),
    .desc_we(desc_we), .desc_slot(desc_slot), .desc_sel(desc_sel), .desc_wdata(desc_wdata),
    .prod_we(prod_we), .prod_wdata(prod_wdata), .run_ctrl(run_ctrl),
    .cons_idx(cons_idx),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_beats(rd_req_beats),
    .rd_dat_valid(rd_dat_valid), .rd_dat_ready(rd_dat_ready), .rd_dat(rd_dat),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_crc(tx_crc)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [63:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // Memory model and stream sink, all driving done at the falling edge.
  int          cyc = 0;
  bit          bp_mode = 1'b0;
  logic [63:0] mm_addr = '0;
  int          mm_left = 0;
  bit          dv_hold = 1'b0;
  logic [63:0] rq_addr [64];
  int          rq_beats [64];
  int          rq_n = 0;
  logic [7:0]  cp_data [512];
  bit          cp_sof [512];
  bit          cp_eof [512];
  bit          cp_crc [512];
  int          cp_n = 0;

  initial begin
    rd_req_ready = 1'b0;
    rd_dat_valid = 1'b0;
    rd_dat       = '0;
    tx_ready     = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        mm_left = 0;
        dv_hold = 1'b0;
        continue;
      end
      tx_ready     = bp_mode ? (cyc % 3 != 0) : 1'b1;
      rd_req_ready = bp_mode ? (cyc % 4 == 0) : 1'b1;
      rd_dat_valid = (mm_left > 0) && (dv_hold || !bp_mode || (cyc % 5 != 1));
      rd_dat       = pat(mm_addr);
      #1;
      dv_hold = rd_dat_valid && !rd_dat_ready;
      if (tx_valid && tx_ready) begin
        if (cp_n < 512) begin
          cp_data[cp_n] = tx_data;
          cp_sof[cp_n]  = tx_sof;
          cp_eof[cp_n]  = tx_eof;
          cp_crc[cp_n]  = tx_crc;
        end
        cp_n++;
      end
      if (rd_dat_valid && rd_dat_ready) begin
        mm_addr = mm_addr + 64'd1;
        mm_left--;
      end
      if (rd_req_valid && rd_req_ready) begin
        if (rq_n < 64) begin
          rq_addr[rq_n]  = rd_req_addr;
          rq_beats[rq_n] = int'(rd_req_beats);
        end
        rq_n++;
        mm_addr = rd_req_addr;
        mm_left = int'(rd_req_beats);
      end
    end
  end

  task automatic put_desc(input int slot, input int len, input logic [31:0] flags,
                          input logic [63:0] addr, input bit full);
    @(negedge clk);
    desc_we = 1'b1; desc_slot = slot[7:0]; desc_sel = 2'd0;
    desc_wdata = (32'(len) << 16) | flags;
    if (full) begin
      @(negedge clk); desc_sel = 2'd1; desc_wdata = addr[31:0];
      @(negedge clk); desc_sel = 2'd2; desc_wdata = addr[63:32];
    end
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic post(input int p);
    @(negedge clk); prod_we = 1'b1; prod_wdata = p[15:0];
    @(negedge clk); prod_we = 1'b0;
  endtask

  task automatic clear_logs;
    @(negedge clk); cp_n = 0; rq_n = 0;
  endtask

  task automatic wait_cons(input int target, input int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (cons_idx == target[15:0]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_buf(input int first, input logic [63:0] base, input int len,
                           input bit sop, input bit eop, input bit crc, input string tag);
    int dbad = 0, fbad = 0, crcbad = 0;
    for (int i = 0; i < len; i++) begin
      if (cp_data[first + i] != pat(base + 64'(i))) dbad++;
      if (cp_sof[first + i] != (sop && i == 0)) fbad++;
      if (cp_eof[first + i] != (eop && i == len - 1)) fbad++;
      if (cp_crc[first + i] != crc) crcbad++;
    end
    check(dbad == 0, {"R3 byte order ", tag}, dbad, 0);
    check(fbad == 0, {"R5 start/end markers ", tag}, fbad, 0);
    check(crcbad == 0, {"R5 crc flag ", tag}, crcbad, 0);
  endtask

  task automatic t_reset;
    check(cons_idx == 16'd0, "R1 cons after reset", cons_idx, 0);
    check(!rd_req_valid, "R1 no request after reset", rd_req_valid, 0);
    check(!tx_valid, "R1 no byte after reset", tx_valid, 0);
  endtask

  task automatic t_single;
    bit ok;
    logic [63:0] a = 64'h0000_0001_0000_1000;
    clear_logs();
    put_desc(0, 20, F_SOP | F_EOP | F_CRC, a, 1'b1);
    post(1);
    wait_cons(1, 400, ok);
    check(ok, "R6 cons after single frame", cons_idx, 1);
    check(cp_n == 20, "R3 single frame length", cp_n, 20);
    check_buf(0, a, 20, 1'b1, 1'b1, 1'b1, "single");
    check(rq_n == 3, "R4 burst count", rq_n, 3);
    check(rq_beats[0] == 8 && rq_beats[1] == 8 && rq_beats[2] == 4,
          "R4 burst sizes (third)", rq_beats[2], 4);
    check(rq_addr[0] == a && rq_addr[1] == a + 64'd8 && rq_addr[2] == a + 64'd16,
          "R4 burst addresses (third)", rq_addr[2], a + 64'd16);
    idle_cycles(30);
    check(cp_n == 20 && rq_n == 3, "R2 quiet when caught up", cp_n, 20);
  endtask

  task automatic t_multi;
    bit ok;
    logic [63:0] a = 64'h0000_0000_0000_3300;
    logic [63:0] b = 64'h0000_0000_0000_4410;
    clear_logs();
    put_desc(1, 5, F_SOP | F_CRC, a, 1'b1);
    put_desc(2, 3, F_EOP | F_CRC, b, 1'b1);
    post(2);
    for (int i = 0; i < 200 && cp_n < 5; i++) @(negedge clk);
    idle_cycles(10);
    check(cp_n == 5, "R6 first buffer streamed", cp_n, 5);
    check(cons_idx == 16'd1, "R6 cons held mid frame", cons_idx, 1);
    @(negedge clk); run_ctrl = '0;
    post(3);
    wait_cons(3, 300, ok);
    check(ok, "R7 mid-frame disable finishes frame", cons_idx, 3);
    check(cp_n == 8, "R3 two-buffer frame length", cp_n, 8);
    check_buf(0, a, 5, 1'b1, 1'b0, 1'b1, "first buffer");
    check_buf(5, b, 3, 1'b0, 1'b1, 1'b1, "end buffer");
    @(negedge clk); run_ctrl = RUN_ALL;
  endtask

  task automatic t_zero;
    bit ok;
    clear_logs();
    put_desc(3, 0, F_SOP | F_EOP, 64'h0, 1'b0);
    post(4);
    wait_cons(4, 100, ok);
    check(ok, "R9 zero-length counted", cons_idx, 4);
    idle_cycles(5);
    check(cp_n == 0 && rq_n == 0, "R9 zero-length silent", cp_n + rq_n, 0);
  endtask

  task automatic t_backpressure;
    bit ok;
    logic [63:0] a = 64'h0000_0000_0000_2345;
    clear_logs();
    bp_mode = 1'b1;
    put_desc(4, 13, F_SOP | F_EOP, a, 1'b1);
    post(5);
    wait_cons(5, 800, ok);
    check(ok, "R10 frame completes under stall", cons_idx, 5);
    check(cp_n == 13, "R10 length under stall", cp_n, 13);
    check_buf(0, a, 13, 1'b1, 1'b1, 1'b0, "stalled");
    check(rq_n == 2 && rq_beats[0] == 8 && rq_beats[1] == 5,
          "R4 capped bursts under stall (second)", rq_beats[1], 5);
    idle_cycles(4);
    bp_mode = 1'b0;
  endtask

  task automatic t_enable;
    bit ok;
    logic [63:0] a = 64'h0000_0000_0000_5000;
    clear_logs();
    @(negedge clk); run_ctrl = 18'h0_0001;
    put_desc(5, 6, F_SOP | F_EOP, a, 1'b1);
    post(6);
    idle_cycles(40);
    check(cons_idx == 16'd5, "R7 ring enable clear holds index", cons_idx, 5);
    check(cp_n == 0 && rq_n == 0, "R7 ring enable clear no traffic", cp_n + rq_n, 0);
    @(negedge clk); run_ctrl = 18'h2_0000;
    idle_cycles(40);
    check(cons_idx == 16'd5, "R7 global enable clear holds index", cons_idx, 5);
    check(cp_n == 0 && rq_n == 0, "R7 global enable clear no traffic", cp_n + rq_n, 0);
    @(negedge clk); run_ctrl = RUN_ALL;
    wait_cons(6, 300, ok);
    check(ok, "R7 resumes when both enables set", cons_idx, 6);
    check(cp_n == 6, "R7 resumed frame length", cp_n, 6);
    check_buf(0, a, 6, 1'b1, 1'b1, 1'b0, "resumed");
  endtask

  task automatic t_wrap;
    bit ok;
    logic [63:0] a = 64'h0000_00AB_0000_7700;
    logic [63:0] b = 64'h0000_0000_0000_0120;
    clear_logs();
    for (int s = 6; s < 255; s++) put_desc(s, 0, F_EOP, 64'h0, 1'b0);
    put_desc(255, 9, F_SOP | F_EOP, a, 1'b1);
    put_desc(0, 4, F_SOP | F_EOP | F_CRC, b, 1'b1);
    post(257);
    wait_cons(257, 3000, ok);
    check(ok, "R8 index past slot wrap", cons_idx, 257);
    check(cp_n == 13, "R8 bytes across wrap", cp_n, 13);
    check_buf(0, a, 9, 1'b1, 1'b1, 1'b0, "slot 255");
    check_buf(9, b, 4, 1'b1, 1'b1, 1'b1, "slot 0");
    check(rq_n == 3, "R9 empty descriptors make no requests", rq_n, 3);
  endtask

  initial begin
    rst_n = 1'b0; desc_we = 1'b0; desc_slot = '0; desc_sel = '0; desc_wdata = '0;
    prod_we = 1'b0; prod_wdata = '0; run_ctrl = RUN_ALL;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_zero();
    t_backpressure();
    t_enable();
    t_wrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule